// File: doc/BRIEF.md
# Page Access Permission Checker with Fault Recording

This block judges whether an access is allowed, using the 3-bit access field and the modified bit of the leaf page table entry that a table walker has already found. The kind of access is given by write, instruction-fetch and supervisor flags. In the same cycle the block reports a fault or the rights it grants (read, write, execute), so that a translation cache can be filled.

A fault is either a permission error found here or a nonzero fault code passed on by the walker. On every fault, a fault status register and a fault address register record the event. If a fault arrives before software has read the status of the previous one, the status register shows an overwrite flag. Reading the status register clears it. A no-fault mode lets user-mode accesses through despite a permission error.

Top module: `perm_fault_unit`

## Requirements
- R1: The access index is {is_write, is_fetch, is_super}, with is_write as the most significant bit. On a fault the index is recorded in status bits [7:5].
- R2: A user access (is_super=0) to an entry whose access field is 6 or 7 is a privilege fault, recorded as code 12 (status bits [3:2]=2'b11).
- R3: Any other access is a protection fault, recorded as code 8 (status bits [3:2]=2'b10), when it lacks a right it needs. A plain read needs read, a fetch needs execute, and a write needs write. A write that is also a fetch needs both write and execute.
- R4: The rights tables ({rd,wr,ex}, by access field 0 to 7) are R, RW, RX, RWX, X, R, none, none for user accesses and R, RW, RX, RWX, X, RW, RX, RWX for supervisor accesses. When an access is accepted, rd_ok/wr_ok/ex_ok show those rights. When it faults, all three are 0.
- R5: wr_ok stays 0 while pte_mod is 0. This withholds write permission only and does not by itself cause a fault.
- R6: With nf_mode=1, a permission error on a user access is not reported and the rights are still granted. nf_mode has no effect on supervisor accesses or on walker faults.
- R7: A nonzero walk_code (with bits [1:0] ignored) is a fault. The status records walk_code in place of a permission code, and no rights are granted.
- R8: On a fault, status bit 1 is set. If the status register was nonzero and is not read in the same cycle, the register is first loaded with 1 (bit 0, overwrite) before the new fields are ORed in, so older fields are discarded.
- R9: On every fault, the fault address register takes vaddr with its low PAGE_BITS bits cleared. Otherwise it holds its value.
- R10: A stat_rd pulse with no fault clears the status register on the next clock. When stat_rd and a fault happen in the same cycle, the register holds the new record with no overwrite flag.
- R11: Reset clears both the status register and the fault address register.
- R12: While chk_valid is 0, fault and all rights outputs are 0 and both registers are unaffected by the access inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_valid | input | 1 | An access is presented for checking this cycle |
| acc_field | input | 3 | Access field of the leaf entry |
| pte_mod | input | 1 | Modified bit of the leaf entry |
| is_write | input | 1 | Access writes |
| is_fetch | input | 1 | Access is an instruction fetch |
| is_super | input | 1 | Access is made in supervisor mode |
| vaddr | input | VA_W | Virtual address of the access |
| walk_code | input | STAT_W | Fault code from the walker, already placed at status bit positions; 0 means no walker fault |
| nf_mode | input | 1 | No-fault mode enable |
| stat_rd | input | 1 | Status register is read this cycle (clear on read) |
| fault | output | 1 | The access faults |
| rd_ok | output | 1 | Read right granted |
| wr_ok | output | 1 | Write right granted |
| ex_ok | output | 1 | Execute right granted |
| stat_q | output | STAT_W | Fault status register |
| far_q | output | VA_W | Fault address register |

## Verification
The fault flag and the granted rights come from combinational logic, so they are due in the cycle the access is presented. The bench drives inputs at the falling edge and samples these outputs 1 ns later, before the next rising edge. The status and address registers change at the first rising edge after the access, so the bench checks them at the following falling edge, which is one cycle after the stimulus. Every table vector pulses stat_rd together with the access. This keeps each expected status independent of the vectors before it, and directed sequences then cover overwrite, clear-on-read and idle cycles across back-to-back cycles.

// File: rtl/perm_pkg.sv
package perm_pkg;

   typedef struct packed {
      logic rd;
      logic wr;
      logic ex;
   } rights_t;

   localparam logic [3:0] ERR_NONE = 4'd0;
   localparam logic [3:0] ERR_PROT = 4'd8;
   localparam logic [3:0] ERR_PRIV = 4'd12;

   localparam int ACC_IDX_LSB = 5;
   localparam int VALID_BIT   = 1;
   localparam int OVW_BIT     = 0;

endpackage

// File: rtl/perm_rights_lut.sv
module perm_rights_lut
   import perm_pkg::*;
(
   input  logic [2:0] fld,
   input  logic       is_super,
   output rights_t    base,
   output logic       priv_only
);

   always_comb begin
      base = '0;
      unique case (fld)
         3'd0: base = '{rd: 1'b1, wr: 1'b0, ex: 1'b0};
         3'd1: base = '{rd: 1'b1, wr: 1'b1, ex: 1'b0};
         3'd2: base = '{rd: 1'b1, wr: 1'b0, ex: 1'b1};
         3'd3: base = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};
         3'd4: base = '{rd: 1'b0, wr: 1'b0, ex: 1'b1};
         3'd5: base = '{rd: 1'b1, wr: is_super, ex: 1'b0};
         3'd6: base = '{rd: is_super, wr: 1'b0, ex: is_super};
         3'd7: base = '{rd: is_super, wr: is_super, ex: is_super};
         default: base = '0;
      endcase
   end

   // fields 6 and 7 are reserved for supervisor code
   assign priv_only = fld[2] & fld[1];

endmodule

// File: rtl/perm_err_eval.sv
module perm_err_eval
   import perm_pkg::*;
(
   input  logic [2:0] acc_idx,
   input  rights_t    base,
   input  logic       priv_only,
   output logic [3:0] err
);

   logic want_wr, want_ex, want_rd, user, missing;

   assign want_wr = acc_idx[2];
   assign want_ex = acc_idx[1];
   assign user    = ~acc_idx[0];
   assign want_rd = ~want_wr & ~want_ex;

   assign missing = (want_rd & ~base.rd) | (want_wr & ~base.wr) | (want_ex & ~base.ex);

   always_comb begin
      if (user && priv_only)
         err = ERR_PRIV;
      else if (missing)
         err = ERR_PROT;
      else
         err = ERR_NONE;
   end

endmodule

// File: rtl/fault_status_regs.sv
module fault_status_regs
   import perm_pkg::*;
#(
   parameter int VA_W      = 32,
   parameter int PAGE_BITS = 12,
   parameter int STAT_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rec_en,
   input  logic [STAT_W-1:0] rec_bits,
   input  logic [VA_W-1:0]   vaddr,
   input  logic              stat_rd,
   output logic [STAT_W-1:0] stat_q,
   output logic [VA_W-1:0]   far_q
);

   localparam logic [VA_W-1:0] PG_MASK = ~((VA_W'(1) << PAGE_BITS) - VA_W'(1));

   logic [STAT_W-1:0] seed;

   // an unread earlier record is replaced by the overwrite marker
   assign seed = (stat_q != '0 && !stat_rd) ? STAT_W'(1) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stat_q <= '0;
         far_q  <= '0;
      end else if (rec_en) begin
         stat_q <= seed | rec_bits;
         far_q  <= vaddr & PG_MASK;
      end else if (stat_rd) begin
         stat_q <= '0;
      end
   end

   assert_valid_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rec_en |=> stat_q[VALID_BIT]);

   assert_overwrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rec_en && stat_q != '0 && !stat_rd) |=> stat_q[OVW_BIT]);

   assert_read_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !rec_en) |=> (stat_q == '0));

   assert_far_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rec_en |=> $stable(far_q));

   assert_far_page_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rec_en |=> (far_q[VA_W-1:PAGE_BITS] == $past(vaddr[VA_W-1:PAGE_BITS])));

endmodule

// File: rtl/perm_fault_unit.sv
module perm_fault_unit
   import perm_pkg::*;
#(
   parameter int VA_W        = 32,
   parameter int PAGE_BITS   = 12,
   parameter int STAT_W      = 16,
   parameter bit HAS_NOFAULT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chk_valid,
   input  logic [2:0]        acc_field,
   input  logic              pte_mod,
   input  logic              is_write,
   input  logic              is_fetch,
   input  logic              is_super,
   input  logic [VA_W-1:0]   vaddr,
   input  logic [STAT_W-1:0] walk_code,
   input  logic              nf_mode,
   input  logic              stat_rd,
   output logic              fault,
   output logic              rd_ok,
   output logic              wr_ok,
   output logic              ex_ok,
   output logic [STAT_W-1:0] stat_q,
   output logic [VA_W-1:0]   far_q
);

   localparam int MIN_STAT_W = 10;

   if (STAT_W < MIN_STAT_W) begin : g_bad_stat_w
      $error("perm_fault_unit: STAT_W must hold index and walker fields");
   end
   if (PAGE_BITS < 1 || PAGE_BITS >= VA_W) begin : g_bad_page
      $error("perm_fault_unit: PAGE_BITS out of range");
   end

   logic [2:0]        acc_idx;
   rights_t           base, grant;
   logic              priv_only;
   logic [3:0]        err;
   logic              perm_hit, walk_hit;
   logic [STAT_W-1:0] walk_bits, code_bits, rec_bits;

   assign acc_idx = {is_write, is_fetch, is_super};

   perm_rights_lut u_lut (
      .fld       (acc_field),
      .is_super  (is_super),
      .base      (base),
      .priv_only (priv_only)
   );

   perm_err_eval u_eval (
      .acc_idx   (acc_idx),
      .base      (base),
      .priv_only (priv_only),
      .err       (err)
   );

   if (HAS_NOFAULT) begin : g_nofault
      assign perm_hit = (err != ERR_NONE) && !(nf_mode && !is_super);
   end else begin : g_strict
      logic nf_unused;
      assign nf_unused = nf_mode;
      assign perm_hit  = (err != ERR_NONE) && !nf_unused | (err != ERR_NONE);
   end

   assign walk_bits = walk_code & ~STAT_W'(3);
   assign walk_hit  = walk_bits != '0;
   assign fault     = chk_valid & (walk_hit | perm_hit);

   always_comb begin
      grant    = base;
      grant.wr = base.wr & pte_mod;
   end

   assign rd_ok = chk_valid & ~fault & grant.rd;
   assign wr_ok = chk_valid & ~fault & grant.wr;
   assign ex_ok = chk_valid & ~fault & grant.ex;

   assign code_bits = walk_hit ? walk_bits : STAT_W'(err);
   assign rec_bits  = (STAT_W'(acc_idx) << ACC_IDX_LSB) | code_bits
                      | (STAT_W'(1) << VALID_BIT);

   fault_status_regs #(
      .VA_W      (VA_W),
      .PAGE_BITS (PAGE_BITS),
      .STAT_W    (STAT_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .rec_en   (fault),
      .rec_bits (rec_bits),
      .vaddr    (vaddr),
      .stat_rd  (stat_rd),
      .stat_q   (stat_q),
      .far_q    (far_q)
   );

   assert_no_rights_on_fault_R4: assert property (@(posedge clk) disable iff (!rst_n)
      fault |-> !(rd_ok || wr_ok || ex_ok));

   assert_wr_needs_mod_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ok |-> pte_mod);

   assert_user_priv_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && !is_super && acc_field[2:1] == 2'b11 && !nf_mode) |-> fault);

   assert_walker_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && walk_code[STAT_W-1:2] != '0) |-> fault);

   assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_valid |-> !(fault || rd_ok || wr_ok || ex_ok));

   assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!chk_valid && !stat_rd) |=> $stable(stat_q));

endmodule

// File: tb/test_perm_fault_unit.sv
module test_perm_fault_unit;

   localparam int VA_W   = 32;
   localparam int STAT_W = 16;
   localparam int NVEC   = 19;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              chk_valid = 1'b0;
   logic [2:0]        acc_field = '0;
   logic              pte_mod = 1'b0;
   logic              is_write = 1'b0;
   logic              is_fetch = 1'b0;
   logic              is_super = 1'b0;
   logic [VA_W-1:0]   vaddr = '0;
   logic [STAT_W-1:0] walk_code = '0;
   logic              nf_mode = 1'b0;
   logic              stat_rd = 1'b0;
   logic              fault, rd_ok, wr_ok, ex_ok;
   logic [STAT_W-1:0] stat_q;
   logic [VA_W-1:0]   far_q;

   int checks = 0;
   int failures = 0;

   always #4 clk = ~clk;

   perm_fault_unit i_perm_fault_unit (
      .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .acc_field(acc_field),
      .pte_mod(pte_mod), .is_write(is_write), .is_fetch(is_fetch), .is_super(is_super),
      .vaddr(vaddr), .walk_code(walk_code), .nf_mode(nf_mode), .stat_rd(stat_rd),
      .fault(fault), .rd_ok(rd_ok), .wr_ok(wr_ok), .ex_ok(ex_ok),
      .stat_q(stat_q), .far_q(far_q)
   );

   // {idx[2:0]={w,f,s}, field[2:0], mod, nf, exp_fault, exp_rights{r,w,x}, exp_code(3=12,2=8)}
   localparam logic [13:0] VEC [NVEC] = '{
      {3'd1, 3'd0, 1'b1, 1'b0, 1'b0, 3'b100, 2'd0},
      {3'd0, 3'd5, 1'b1, 1'b0, 1'b0, 3'b100, 2'd0},
      {3'd1, 3'd5, 1'b1, 1'b0, 1'b0, 3'b110, 2'd0},
      {3'd1, 3'd5, 1'b0, 1'b0, 1'b0, 3'b100, 2'd0},
      {3'd0, 3'd6, 1'b1, 1'b0, 1'b1, 3'b000, 2'd3},
      {3'd1, 3'd7, 1'b1, 1'b0, 1'b0, 3'b111, 2'd0},
      {3'd0, 3'd4, 1'b1, 1'b0, 1'b1, 3'b000, 2'd2},
      {3'd2, 3'd4, 1'b0, 1'b0, 1'b0, 3'b001, 2'd0},
      {3'd3, 3'd5, 1'b1, 1'b0, 1'b1, 3'b000, 2'd2},
      {3'd4, 3'd1, 1'b1, 1'b0, 1'b0, 3'b110, 2'd0},
      {3'd4, 3'd1, 1'b0, 1'b0, 1'b0, 3'b100, 2'd0},
      {3'd5, 3'd6, 1'b1, 1'b0, 1'b1, 3'b000, 2'd2},
      {3'd7, 3'd7, 1'b1, 1'b0, 1'b0, 3'b111, 2'd0},
      {3'd6, 3'd3, 1'b1, 1'b0, 1'b0, 3'b111, 2'd0},
      {3'd6, 3'd2, 1'b1, 1'b0, 1'b1, 3'b000, 2'd2},
      {3'd0, 3'd7, 1'b1, 1'b1, 1'b0, 3'b000, 2'd0},
      {3'd4, 3'd0, 1'b1, 1'b1, 1'b0, 3'b100, 2'd0},
      {3'd1, 3'd4, 1'b1, 1'b1, 1'b1, 3'b000, 2'd2},
      {3'd2, 3'd6, 1'b1, 1'b0, 1'b1, 3'b000, 2'd3}
   };

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   endtask

   task automatic drive(input logic [2:0] idx, input logic [2:0] fld, input logic m,
                        input logic nf, input logic [STAT_W-1:0] wc,
                        input logic [VA_W-1:0] va, input logic v, input logic rd);
      {is_write, is_fetch, is_super} = idx;
      acc_field = fld; pte_mod = m; nf_mode = nf; walk_code = wc;
      vaddr = va; chk_valid = v; stat_rd = rd;
   endtask

   initial begin
      #(8 * 20000);
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [VA_W-1:0]   far_m;
      logic [STAT_W-1:0] exp_st;
      string             tag;

      repeat (3) @(negedge clk);
      check("R11", "status at reset", 32'(stat_q), 32'h0);
      check("R11", "address at reset", far_q, 32'h0);
      rst_n = 1'b1;
      far_m = '0;

      for (int i = 0; i < NVEC; i++) begin
         logic [13:0] v;
         logic [VA_W-1:0] va;
         v  = VEC[i];
         va = 32'h1000_0ABC + 32'(i) * 32'h0010_1111;
         @(negedge clk);
         drive(v[13:11], v[10:8], v[7], v[6], '0, va, 1'b1, 1'b1);
         #1;
         if (v[1:0] == 2'd3) tag = "R2";
         else if (v[1:0] == 2'd2) tag = "R3";
         else if (v[6]) tag = "R6";
         else if (!v[7]) tag = "R5";
         else tag = "R4";
         check(tag, $sformatf("fault vec%0d", i), 32'(fault), 32'(v[5]));
         check(tag, $sformatf("rights vec%0d", i), 32'({rd_ok, wr_ok, ex_ok}), 32'(v[4:2]));
         @(negedge clk);
         chk_valid = 1'b0; stat_rd = 1'b0;
         exp_st = v[5] ? ((STAT_W'(v[13:11]) << 5) | (STAT_W'(v[1:0]) << 2) | STAT_W'(2)) : '0;
         if (v[5]) far_m = va & 32'hFFFF_F000;
         check("R1", $sformatf("status vec%0d", i), 32'(stat_q), 32'(exp_st));
         check("R9", $sformatf("address vec%0d", i), far_q, far_m);
      end

      // R10: read alone clears, address unchanged
      drive(3'd0, 3'd0, 1'b0, 1'b0, '0, 32'h0, 1'b0, 1'b1);
      @(negedge clk);
      check("R10", "clear on read", 32'(stat_q), 32'h0);
      check("R9", "address held on read", far_q, far_m);

      // R8: fault into empty register, then a second unread fault
      drive(3'd0, 3'd6, 1'b1, 1'b0, '0, 32'h2222_2345, 1'b1, 1'b0);
      @(negedge clk);
      check("R8", "first record", 32'(stat_q), 32'h0E);
      drive(3'd5, 3'd6, 1'b1, 1'b0, '0, 32'h3333_3FFF, 1'b1, 1'b0);
      @(negedge clk);
      check("R8", "overwrite record", 32'(stat_q), 32'hAB);
      check("R9", "second address", far_q, 32'h3333_3000);

      // R7: walker fault with simultaneous read
      drive(3'd1, 3'd3, 1'b1, 1'b0, 16'h0304, 32'h4444_4567, 1'b1, 1'b1);
      #1;
      check("R7", "walker fault", 32'(fault), 32'h1);
      check("R7", "walker rights", 32'({rd_ok, wr_ok, ex_ok}), 32'h0);
      @(negedge clk);
      check("R7", "walker status", 32'(stat_q), 32'h326);

      // R6: no-fault mode does not hide walker faults
      drive(3'd0, 3'd3, 1'b1, 1'b1, 16'h0107, 32'hFFFF_FFFF, 1'b1, 1'b1);
      #1;
      check("R6", "walker fault under nf", 32'(fault), 32'h1);
      @(negedge clk);
      check("R10", "fresh record with read", 32'(stat_q), 32'h106);
      check("R9", "address all ones", far_q, 32'hFFFF_F000);

      // R12: idle cycle with faulting inputs
      drive(3'd0, 3'd6, 1'b1, 1'b0, 16'h0304, 32'h5555_5000, 1'b0, 1'b0);
      #1;
      check("R12", "idle fault", 32'(fault), 32'h0);
      check("R12", "idle rights", 32'({rd_ok, wr_ok, ex_ok}), 32'h0);
      @(negedge clk);
      check("R12", "idle status", 32'(stat_q), 32'h106);
      check("R12", "idle address", far_q, 32'hFFFF_F000);

      finish_run();
   end

endmodule